// File: doc/BRIEF.md
# Interrupt priority level gating unit

This block sits between a set of peripheral interrupt request lines and the CPU. It holds a programmable 2-bit priority level for every request source in small byte-wide registers. Software can read and write these registers at any time. Each source has one gated output. When gating is on, that output is raised only while the source requests and the source's level is not below the current 2-bit priority mask. Level 3 is the most urgent and level 0 the least.

The mask comes in from outside the block. A low-power stop indicator replaces the mask with zero, so every pending request can wake the core. When the module enable is low, the gating is removed entirely and every request line reaches its output unchanged. The block does not choose between requests that are pending together. Several outputs may be high at once, and the CPU's own fixed arbitration orders them.

Top module: `ipl_gating_unit`

## Requirements
- R1: While reset is held, and after reset until the first write, every level field reads back as 0.
- R2: Source k owns bits [2*(k%4)+1 : 2*(k%4)] of register k/4. A write to a register that exists stores all of its fields from `wdata_i` at the clock edge, and `rdata_o` for that address then returns the stored byte.
- R3: A level write takes part in gating from the cycle after the write edge. In the cycle of the write, the old level still applies.
- R4: With `en_i` high and `stop_i` low, `irq_o[k]` is 1 exactly when `irq_req_i[k]` is 1 and level[k] >= `mask_i`, compared as unsigned numbers.
- R5: With `en_i` high and `stop_i` high, the comparison uses 0 instead of `mask_i`, so every active request reaches its output.
- R6: With `en_i` low, `irq_o` equals `irq_req_i` whatever the levels, mask and stop indicator are.
- R7: An address at or beyond the register count reads as 0x00, and a write to it changes no level.
- R8: Bit pairs in the last register that belong to no source read as 0, and writes to them are ignored.
- R9: The path from request, level and mask to `irq_o` has no register: a change on `irq_req_i` shows on `irq_o` within the same clock cycle.
- R10: Outputs are independent. Any number of them can be high together, and no source suppresses another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| en_i | input | 1 | Module enable; low bypasses gating |
| stop_i | input | 1 | Low-power stop indicator; forces mask to 0 |
| mask_i | input | 2 | Current priority mask |
| irq_req_i | input | NUM_SRC | Raw request lines |
| irq_o | output | NUM_SRC | Gated requests toward the CPU |

## Verification
The write-readback assertion checks a write only when `addr_i` does not change in the following cycle. If the address moves, the check does not apply. The bench therefore holds the address across at least one edge after each directed write. Its random phase changes the address freely, and the per-clock model comparison covers that traffic instead of the assertion. The remaining assertions assume that the request, mask, enable and stop inputs are already settled at the sampling edge. The bench meets this by driving all inputs one nanosecond after the rising edge.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  localparam int LVL_W  = 2;
  localparam int REG_W  = 8;
  localparam int FIELDS = REG_W / LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/ipl_regfile.sv
module ipl_regfile
  import ipl_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int ADDR_W  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [REG_W-1:0]             wdata_i,
  output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_o
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_fld
    localparam int RIDX = k / FIELDS;
    localparam int FIDX = k % FIELDS;
    lvl_t lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        lvl_q <= '0;
      else if (we_i && addr_i == ADDR_W'(RIDX))
        lvl_q <= wdata_i[FIDX*LVL_W +: LVL_W];
    end
    assign lvl_o[k] = lvl_q;
  end
endmodule

// File: rtl/ipl_rdmux.sv
module ipl_rdmux
  import ipl_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int ADDR_W  = 4
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic [REG_W-1:0]              rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (addr_i == ADDR_W'(k / FIELDS))
        rdata_o[(k % FIELDS)*LVL_W +: LVL_W] = lvl_i[k];
    end
  end
endmodule

// File: rtl/ipl_gate.sv
module ipl_gate
  import ipl_pkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic                          en_i,
  input  logic                          stop_i,
  input  logic [LVL_W-1:0]              mask_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  input  logic [NUM_SRC-1:0]            req_i,
  output logic [NUM_SRC-1:0]            irq_o
);
  lvl_t eff_mask;
  assign eff_mask = stop_i ? '0 : mask_i;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic pass;
    assign pass     = lvl_i[k] >= eff_mask;
    assign irq_o[k] = en_i ? (req_i[k] & pass) : req_i[k];
  end
endmodule

// File: rtl/ipl_gating_unit.sv
module ipl_gating_unit
  import ipl_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int ADDR_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic               en_i,
  input  logic               stop_i,
  input  logic [1:0]         mask_i,
  input  logic [NUM_SRC-1:0] irq_req_i,
  output logic [NUM_SRC-1:0] irq_o
);
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl;

  ipl_regfile #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .lvl_o  (lvl)
  );

  ipl_rdmux #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_rdmux (
    .addr_i (addr_i),
    .lvl_i  (lvl),
    .rdata_o(rdata_o)
  );

  ipl_gate #(.NUM_SRC(NUM_SRC)) i_gate (
    .en_i  (en_i),
    .stop_i(stop_i),
    .mask_i(mask_i),
    .lvl_i (lvl),
    .req_i (irq_req_i),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/ipl_gating_chk.sv
module ipl_gating_chk
  import ipl_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int ADDR_W  = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [7:0]         wdata_i,
  input logic [7:0]         rdata_o,
  input logic               en_i,
  input logic               stop_i,
  input logic [1:0]         mask_i,
  input logic [NUM_SRC-1:0] irq_req_i,
  input logic [NUM_SRC-1:0] irq_o
);
  localparam int NUM_REGS  = (NUM_SRC + FIELDS - 1) / FIELDS;
  localparam int LAST_FLDS = NUM_SRC - (NUM_REGS - 1) * FIELDS;
  localparam logic [7:0] LAST_USED = 8'((1 << (LAST_FLDS * LVL_W)) - 1);

  function automatic logic [7:0] used_bits(logic [ADDR_W-1:0] a);
    return (int'(a) == NUM_REGS - 1) ? LAST_USED : 8'hFF;
  endfunction

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) rst_clear_chk: assert (rdata_o == 8'h00);
  end

  // R2
  wr_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(addr_i) < NUM_REGS) |=>
      ((addr_i != $past(addr_i)) || (rdata_o == ($past(wdata_i) & used_bits(addr_i)))));

  // R4
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~irq_req_i) == '0);

  // R4
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mask_i == 2'd0) |-> irq_o == irq_req_i);

  // R5
  stop_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && stop_i) |-> irq_o == irq_req_i);

  // R6
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> irq_o == irq_req_i);

  // R7
  oob_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) >= NUM_REGS) |-> rdata_o == 8'h00);

  // R8
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) == NUM_REGS - 1) |-> (rdata_o & ~LAST_USED) == 8'h00);
endmodule

bind ipl_gating_unit ipl_gating_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .en_i     (en_i),
  .stop_i   (stop_i),
  .mask_i   (mask_i),
  .irq_req_i(irq_req_i),
  .irq_o    (irq_o)
);

// File: tb/test_ipl_gating_unit.sv
module test_ipl_gating_unit;
  localparam int NSRC = 6;
  localparam int AW   = 4;
  localparam int NREG = (NSRC + 3) / 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            we = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [7:0]      wdata = '0;
  logic [7:0]      rdata;
  logic            en = 1'b0;
  logic            stop = 1'b0;
  logic [1:0]      mask = '0;
  logic [NSRC-1:0] req = '0;
  logic [NSRC-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit run = 1'b0;
  bit done = 1'b0;
  int lvl_m [NSRC];

  always #2 clk = ~clk;

  ipl_gating_unit #(.NUM_SRC(NSRC), .ADDR_W(AW)) i_ipl_gating_unit (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .en_i(en), .stop_i(stop), .mask_i(mask),
    .irq_req_i(req), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_rd(int a);
    logic [7:0] r = '0;
    if (a < NREG)
      for (int k = 0; k < NSRC; k++)
        if (k / 4 == a) r = r | 8'(lvl_m[k] << (2 * (k % 4)));
    return r;
  endfunction

  function automatic logic [NSRC-1:0] model_irq();
    logic [NSRC-1:0] e = '0;
    int m = stop ? 0 : int'(mask);
    for (int k = 0; k < NSRC; k++)
      e[k] = en ? (req[k] && lvl_m[k] >= m) : req[k];
    return e;
  endfunction

  initial for (int k = 0; k < NSRC; k++) lvl_m[k] = 0;

  always @(posedge clk) begin
    if (!rst_n)
      for (int k = 0; k < NSRC; k++) lvl_m[k] = 0;
    else if (we && int'(addr) < NREG)
      for (int k = 0; k < NSRC; k++)
        if (k / 4 == int'(addr)) lvl_m[k] = int'((wdata >> (2 * (k % 4))) & 8'h03);
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (run) begin
      chk(!en ? "R6" : (stop ? "R5" : "R4"), 32'(irq), 32'(model_irq()));
      chk(int'(addr) >= NREG ? "R7" : "R2", 32'(rdata), 32'(model_rd(int'(addr))));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(int a, logic [7:0] d);
    we = 1'b1; addr = AW'(a); wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a, logic [7:0] exp);
    addr = AW'(a);
    @(negedge clk);
    chk(tag, 32'(rdata), 32'(exp));
    step();
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 32'(rdata), 32'h0);
    addr = AW'(1);
    @(negedge clk);
    chk("R1", 32'(rdata), 32'h0);
    step();
    rst_n = 1'b1;
    step();
    run = 1'b1;
    rd_chk("R1", 0, 8'h00);
    rd_chk("R1", 1, 8'h00);

    // layout: src0..3 = 0,1,2,3 ; src4 = 3, src5 = 2
    wr(0, 8'hE4);
    rd_chk("R2", 0, 8'hE4);
    wr(1, 8'hFB);
    rd_chk("R8", 1, 8'h0B);

    wr(5, 8'hFF);
    rd_chk("R7", 5, 8'h00);
    rd_chk("R7", 0, 8'hE4);
    rd_chk("R7", 1, 8'h0B);

    // R4 mask sweep, all requesting
    en = 1'b1; stop = 1'b0; req = '1;
    for (int m = 0; m < 4; m++) begin
      mask = 2'(m);
      @(negedge clk);
      chk("R4", 32'(irq), 32'(model_irq()));
      step();
    end
    mask = 2'd2;
    @(negedge clk);
    chk("R4", 32'(irq), 32'b111100);
    step();

    // R5 stop forces mask to zero
    stop = 1'b1; mask = 2'd3;
    @(negedge clk);
    chk("R5", 32'(irq), 32'b111111);
    step();
    stop = 1'b0;

    // R6 bypass
    en = 1'b0; mask = 2'd3; req = 6'b010101;
    @(negedge clk);
    chk("R6", 32'(irq), 32'b010101);
    step();

    // R3 write latency
    en = 1'b1; mask = 2'd3; req = 6'b000001;
    we = 1'b1; addr = AW'(0); wdata = 8'hE7;
    @(negedge clk);
    chk("R3", 32'(irq), 32'h0);
    step();
    we = 1'b0;
    @(negedge clk);
    chk("R3", 32'(irq), 32'h1);
    step();

    // R9 combinational path, mid-cycle change
    req = 6'b001000;
    #1;
    chk("R9", 32'(irq), 32'b001000);
    req = 6'b000100;
    #0.5;
    chk("R9", 32'(irq), 32'b000000);
    step();

    // R10 simultaneous outputs
    wr(0, 8'hFF);
    wr(1, 8'h0F);
    mask = 2'd2; req = '1;
    @(negedge clk);
    chk("R10", 32'(irq), 32'b111111);
    step();

    // random traffic checked every clock
    for (int i = 0; i < 400; i++) begin
      en    = 1'($urandom_range(0, 3) != 0);
      stop  = 1'($urandom_range(0, 4) == 0);
      mask  = 2'($urandom_range(0, 3));
      req   = NSRC'($urandom);
      we    = 1'($urandom_range(0, 2) == 0);
      addr  = AW'($urandom_range(0, 5));
      wdata = 8'($urandom);
      step();
    end
    we = 1'b0;
    step();

    run = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule